// File: doc/BRIEF.md
# Register Hazard Forward and Stall Control

This block is the control for read-after-write hazards on the register file of a five-stage in-order pipeline. The stages are fetch, decode with operand read, ALU, memory and write-back. The decoder gives the block one instruction's class and register fields each cycle. The block keeps its own shadow copy of those fields for the ALU, memory and write-back stages. Each cycle it compares the destination fields held in the later stages with the source fields that the younger instructions still need. From that comparison it drives the operand multiplexer selects and the stall signals.

Registers are written only at the end of write-back, and data memory is touched only in the memory stage. As a result, flow dependences through registers are the only hazard to handle. The register file is assumed to write in the first half of a cycle and read in the second half, so an instruction in write-back is already visible to the decode stage.

Results are forwarded from the memory-stage result (Z4) or the write-back result (Z5) to three places: the ALU inputs, the store-data path, and the branch operands read in decode. The pipeline stalls only when forwarding cannot help. This happens in two cases: a loaded value that the next instruction needs in the ALU stage, and a branch operand produced one instruction earlier (or two instructions earlier by a load). During a stall, fetch and decode hold their registers and a bubble enters the ALU stage.

Top module: `hz_unit`

## Requirements
- R1: While reset is high, the three shadow stages hold the nop class (code 0). With a nop in decode, every output is 0.
- R2: Class codes are nop 0, ALU 1, load 2, load-address 3, store 4, branch 5, branch-and-link 6. The classes ALU, load, load-address and branch-and-link write register ra. Select codes are 0 for the register value, 1 for Z4 and 2 for Z5. fwd_x_sel is 1 when the ALU-stage instruction reads rb (classes ALU, load, load-address, store) and the memory-stage instruction is a writer other than load whose ra equals that rb. fwd_y_sel follows the same rule for rc, and applies only to an ALU-class instruction with d_imm low.
- R3: A select is 2 when the write-back instruction is a writer whose ra matches and the memory stage does not already supply the value. The memory stage has priority over write-back.
- R4: A source or destination field of 0 never causes a forward or a stall. An immediate-form ALU instruction never selects a forward on the Y operand and never stalls on rc.
- R5: A stall raises pause_if, pause_id and bubble_ex together in the same cycle. On the next clock the ALU stage holds a nop.
- R6: A load in the ALU stage whose ra matches a stage-3 source (rb or rc, as in R2) of the decode instruction causes exactly one stall cycle. The operand then comes from Z5. Adjacent dependent ALU instructions cause no stall.
- R7: A branch (code 5 or 6) reads rb and rc in decode. It stalls while a matching writer is in the ALU stage, and while a matching load is in the memory stage. So it stalls 1 cycle after an ALU producer and 2 cycles after a load. br_tgt_z4 and br_cnd_z4 are high when a matching writer other than load is in the memory stage.
- R8: Store data (the store's ra) never stalls. st_data_sel picks Z4 or Z5 for a store in the ALU stage, using the rule of R2 and R3. st_late_z5 is high when a store in the memory stage has a nonzero ra that matches the ra of a writer in write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| d_cls | input | 3 | Class of the instruction in decode |
| d_ra | input | 5 | Destination or store-data register in decode |
| d_rb | input | 5 | First source register in decode |
| d_rc | input | 5 | Second source register in decode |
| d_imm | input | 1 | Decode instruction uses an immediate as second operand |
| fwd_x_sel | output | 2 | ALU X operand select |
| fwd_y_sel | output | 2 | ALU Y operand select |
| st_data_sel | output | 2 | Store data select for the ALU-stage store |
| st_late_z5 | output | 1 | Memory-stage store data taken from Z5 |
| br_tgt_z4 | output | 1 | Branch target operand taken from Z4 |
| br_cnd_z4 | output | 1 | Branch condition operand taken from Z4 |
| pause_if | output | 1 | Hold fetch-stage registers |
| pause_id | output | 1 | Hold decode-stage registers |
| bubble_ex | output | 1 | Force a nop into the ALU stage |

## Verification
The selects depend on the shadow stages, so a wrong shadow entry shows up at the ports within one to three cycles of the instruction that entered it. It appears as a select pointing at the wrong result register, or a missing one, when a later consumer arrives. A missing bubble leaves the stalled instruction duplicated in the ALU stage. The next cycle's selects then treat it as a producer, which the per-cycle comparison against the behavioural model catches. Stall counts for the load-use and branch cases are also checked as totals per instruction.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int unsigned RIDX_W = 5;

  typedef enum logic [2:0] {
    IC_NOP    = 3'd0,
    IC_ALU    = 3'd1,
    IC_LOAD   = 3'd2,
    IC_LADR   = 3'd3,
    IC_STORE  = 3'd4,
    IC_BRANCH = 3'd5,
    IC_BRL    = 3'd6
  } iclass_e;

  typedef logic [RIDX_W-1:0] ridx_t;

  typedef struct packed {
    iclass_e cls;
    ridx_t   ra;
    ridx_t   rb;
    ridx_t   rc;
    logic    imm;
  } ctl_t;

  localparam ctl_t CTL_NOP = '{cls: IC_NOP, ra: '0, rb: '0, rc: '0, imm: 1'b0};

  localparam logic [1:0] SEL_REG = 2'd0;
  localparam logic [1:0] SEL_Z4  = 2'd1;
  localparam logic [1:0] SEL_Z5  = 2'd2;

  // class writes its ra in write-back
  function automatic logic f_writes(iclass_e c);
    case (c)
      IC_ALU, IC_LOAD, IC_LADR, IC_BRL: return 1'b1;
      default:                          return 1'b0;
    endcase
  endfunction

  // result already sits in Z4 while in the memory stage
  function automatic logic f_z4_ready(iclass_e c);
    return f_writes(c) && (c != IC_LOAD);
  endfunction

  // rb consumed by the ALU stage (operand or address modifier)
  function automatic logic f_uses_rb(iclass_e c);
    case (c)
      IC_ALU, IC_LOAD, IC_LADR, IC_STORE: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

  function automatic logic f_uses_rc(iclass_e c, logic imm);
    return (c == IC_ALU) && !imm;
  endfunction

  function automatic logic f_is_branch(iclass_e c);
    return (c == IC_BRANCH) || (c == IC_BRL);
  endfunction

  // a match on register 0 never counts
  function automatic logic f_hit(ridx_t dst, ridx_t src);
    return (src != '0) && (dst == src);
  endfunction
endpackage

// File: rtl/hz_ctl_pipe.sv
module hz_ctl_pipe
  import hz_pkg::*;
#(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inject_nop,
  input  ctl_t             entry,
  output ctl_t [DEPTH-1:0] stg
);
  ctl_t q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)             q[g] <= CTL_NOP;
        else if (inject_nop) q[g] <= CTL_NOP;
        else                 q[g] <= entry;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) q[g] <= CTL_NOP;
        else     q[g] <= q[g-1];
      end
    end
    assign stg[g] = q[g];
  end
endmodule

// File: rtl/hz_opnd_sel.sv
module hz_opnd_sel
  import hz_pkg::*;
#(
  parameter bit USE_NEAR = 1'b1,
  parameter bit USE_FAR  = 1'b1
) (
  input  logic       want,
  input  ridx_t      src,
  input  ctl_t       near,
  input  ctl_t       far,
  output logic [1:0] sel,
  output logic       near_hit,
  output logic       far_hit
);
  always_comb begin
    near_hit = USE_NEAR && want && f_z4_ready(near.cls) && f_hit(near.ra, src);
    far_hit  = USE_FAR  && want && f_writes(far.cls)    && f_hit(far.ra, src);
    if (near_hit)     sel = SEL_Z4;
    else if (far_hit) sel = SEL_Z5;
    else              sel = SEL_REG;
  end
endmodule

// File: rtl/hz_stall_det.sv
module hz_stall_det
  import hz_pkg::*;
(
  input  ctl_t dec,
  input  ctl_t s3,
  input  ctl_t s4,
  output logic load_use,
  output logic br_wait,
  output logic stall
);
  logic rb_need3, rc_need3, br_src_s3, br_src_s4;

  always_comb begin
    rb_need3  = f_uses_rb(dec.cls) && f_hit(s3.ra, dec.rb);
    rc_need3  = f_uses_rc(dec.cls, dec.imm) && f_hit(s3.ra, dec.rc);
    load_use  = (s3.cls == IC_LOAD) && (rb_need3 || rc_need3);
    br_src_s3 = f_writes(s3.cls) && (f_hit(s3.ra, dec.rb) || f_hit(s3.ra, dec.rc));
    br_src_s4 = (s4.cls == IC_LOAD) && (f_hit(s4.ra, dec.rb) || f_hit(s4.ra, dec.rc));
    br_wait   = f_is_branch(dec.cls) && (br_src_s3 || br_src_s4);
    stall     = load_use || br_wait;
  end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        d_cls,
  input  logic [RIDX_W-1:0] d_ra,
  input  logic [RIDX_W-1:0] d_rb,
  input  logic [RIDX_W-1:0] d_rc,
  input  logic              d_imm,
  output logic [1:0]        fwd_x_sel,
  output logic [1:0]        fwd_y_sel,
  output logic [1:0]        st_data_sel,
  output logic              st_late_z5,
  output logic              br_tgt_z4,
  output logic              br_cnd_z4,
  output logic              pause_if,
  output logic              pause_id,
  output logic              bubble_ex
);
  localparam int unsigned SHADOW = 3;
  localparam int unsigned IX_EX  = 0;
  localparam int unsigned IX_MEM = 1;
  localparam int unsigned IX_WB  = 2;

  ctl_t              dec;
  ctl_t [SHADOW-1:0] stg;
  ctl_t              s3, s4, s5;
  logic              stall, load_use, br_wait;
  logic              want_x, want_y, want_sd, want_sd4, want_bt, want_bc;
  logic              x_near, x_far, y_near, y_far, sd_near, sd_far;
  logic              sd4_near, sd4_far, bt_near, bt_far, bc_near, bc_far;
  logic [1:0]        sd4_sel, bt_sel, bc_sel;

  assign dec = '{cls: iclass_e'(d_cls), ra: d_ra, rb: d_rb, rc: d_rc, imm: d_imm};
  assign s3  = stg[IX_EX];
  assign s4  = stg[IX_MEM];
  assign s5  = stg[IX_WB];

  hz_ctl_pipe #(.DEPTH(SHADOW)) u_pipe (
    .clk(clk), .rst(rst), .inject_nop(stall), .entry(dec), .stg(stg)
  );

  hz_stall_det u_stall (
    .dec(dec), .s3(s3), .s4(s4),
    .load_use(load_use), .br_wait(br_wait), .stall(stall)
  );

  assign want_x   = f_uses_rb(s3.cls);
  assign want_y   = f_uses_rc(s3.cls, s3.imm);
  assign want_sd  = (s3.cls == IC_STORE);
  assign want_sd4 = (s4.cls == IC_STORE);
  assign want_bt  = f_is_branch(dec.cls);
  assign want_bc  = f_is_branch(dec.cls);

  hz_opnd_sel #(.USE_NEAR(1'b1), .USE_FAR(1'b1)) u_sel_x (
    .want(want_x), .src(s3.rb), .near(s4), .far(s5),
    .sel(fwd_x_sel), .near_hit(x_near), .far_hit(x_far)
  );
  hz_opnd_sel #(.USE_NEAR(1'b1), .USE_FAR(1'b1)) u_sel_y (
    .want(want_y), .src(s3.rc), .near(s4), .far(s5),
    .sel(fwd_y_sel), .near_hit(y_near), .far_hit(y_far)
  );
  hz_opnd_sel #(.USE_NEAR(1'b1), .USE_FAR(1'b1)) u_sel_sd (
    .want(want_sd), .src(s3.ra), .near(s4), .far(s5),
    .sel(st_data_sel), .near_hit(sd_near), .far_hit(sd_far)
  );
  hz_opnd_sel #(.USE_NEAR(1'b0), .USE_FAR(1'b1)) u_sel_sd4 (
    .want(want_sd4), .src(s4.ra), .near(CTL_NOP), .far(s5),
    .sel(sd4_sel), .near_hit(sd4_near), .far_hit(sd4_far)
  );
  hz_opnd_sel #(.USE_NEAR(1'b1), .USE_FAR(1'b0)) u_sel_bt (
    .want(want_bt), .src(dec.rb), .near(s4), .far(CTL_NOP),
    .sel(bt_sel), .near_hit(bt_near), .far_hit(bt_far)
  );
  hz_opnd_sel #(.USE_NEAR(1'b1), .USE_FAR(1'b0)) u_sel_bc (
    .want(want_bc), .src(dec.rc), .near(s4), .far(CTL_NOP),
    .sel(bc_sel), .near_hit(bc_near), .far_hit(bc_far)
  );

  assign st_late_z5 = (sd4_sel == SEL_Z5);
  assign br_tgt_z4  = (bt_sel == SEL_Z4);
  assign br_cnd_z4  = (bc_sel == SEL_Z4);
  assign pause_if   = stall;
  assign pause_id   = stall;
  assign bubble_ex  = stall;

  // R5
  bubble_lands_chk: assert property (@(posedge clk) disable iff (rst)
    bubble_ex |=> (s3.cls == IC_NOP));

  // R6
  no_load_z4_chk: assert property (@(posedge clk) disable iff (rst)
    (s4.cls == IC_LOAD) |-> !((want_x && f_hit(s4.ra, s3.rb)) || (want_y && f_hit(s4.ra, s3.rc))));

  // R7
  stall_len_chk: assert property (@(posedge clk) disable iff (rst)
    (pause_if && $past(pause_if)) |=> !pause_if);

  // R4
  zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (d_rb == '0 && d_rc == '0) |-> !pause_id);

  // R2
  sel_code_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_x_sel != 2'd3) && (fwd_y_sel != 2'd3) && (st_data_sel != 2'd3));

  // R3
  near_first_chk: assert property (@(posedge clk) disable iff (rst)
    x_near |-> (fwd_x_sel == SEL_Z4));

  // R8
  store_no_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (d_cls == 3'd4 && d_rb == '0) |-> !pause_if);
endmodule

// File: tb/tb_hz_unit.sv
`timescale 1ns/100ps
module tb_hz_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] d_cls;
  logic [4:0] d_ra, d_rb, d_rc;
  logic       d_imm;
  logic [1:0] fwd_x_sel, fwd_y_sel, st_data_sel;
  logic       st_late_z5, br_tgt_z4, br_cnd_z4, pause_if, pause_id, bubble_ex;

  int n_run = 0;
  int n_fail = 0;

  // model: index 1 = ALU stage, 2 = memory stage, 3 = write-back
  int mc[1:3];
  int mra[1:3];
  int mrb[1:3];
  int mrc[1:3];
  bit mim[1:3];

  always #2.5 clk = ~clk;

  hz_unit dut (
    .clk(clk), .rst(rst), .d_cls(d_cls), .d_ra(d_ra), .d_rb(d_rb), .d_rc(d_rc),
    .d_imm(d_imm), .fwd_x_sel(fwd_x_sel), .fwd_y_sel(fwd_y_sel),
    .st_data_sel(st_data_sel), .st_late_z5(st_late_z5), .br_tgt_z4(br_tgt_z4),
    .br_cnd_z4(br_cnd_z4), .pause_if(pause_if), .pause_id(pause_id), .bubble_ex(bubble_ex)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit wr(int c);
    return (c == 1) || (c == 2) || (c == 3) || (c == 6);
  endfunction

  // where a source register would come from, looking at older instructions
  function automatic int from_where(int r, bit with_wb);
    if (r == 0) return 0;
    if (wr(mc[2]) && mc[2] != 2 && mra[2] == r) return 1;
    if (with_wb && wr(mc[3]) && mra[3] == r) return 2;
    return 0;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic issue(input int c, input int ra, input int rb, input int rc,
                       input bit im, output int stalls);
    bit done = 1'b0;
    stalls = 0;
    while (!done) begin
      int ex, ey, esd, esd4, ebt, ebc;
      bit est;
      @(negedge clk);
      d_cls = 3'(c); d_ra = 5'(ra); d_rb = 5'(rb); d_rc = 5'(rc); d_imm = im;
      #1;
      ex   = (mc[1] inside {1, 2, 3, 4}) ? from_where(mrb[1], 1'b1) : 0;
      ey   = (mc[1] == 1 && !mim[1]) ? from_where(mrc[1], 1'b1) : 0;
      esd  = (mc[1] == 4) ? from_where(mra[1], 1'b1) : 0;
      esd4 = (mc[2] == 4 && mra[2] != 0 && wr(mc[3]) && mra[3] == mra[2]) ? 1 : 0;
      ebt  = (c == 5 || c == 6) ? from_where(rb, 1'b0) : 0;
      ebc  = (c == 5 || c == 6) ? from_where(rc, 1'b0) : 0;
      est  = 1'b0;
      if (mc[1] == 2 && mra[1] != 0) begin
        if ((c inside {1, 2, 3, 4}) && rb == mra[1]) est = 1'b1;
        if (c == 1 && !im && rc == mra[1]) est = 1'b1;
      end
      if (c == 5 || c == 6) begin
        foreach (mc[k]) begin
          if (k <= 2) begin
            if ((k == 1 ? wr(mc[1]) : mc[2] == 2) &&
                ((rb != 0 && rb == mra[k]) || (rc != 0 && rc == mra[k]))) est = 1'b1;
          end
        end
      end
      chk(fwd_x_sel == 2'(ex), "R2 R3 x select", fwd_x_sel, ex);
      chk(fwd_y_sel == 2'(ey), "R2 R3 R4 y select", fwd_y_sel, ey);
      chk(st_data_sel == 2'(esd), "R8 store data select", st_data_sel, esd);
      chk(st_late_z5 == esd4[0], "R8 late store data", st_late_z5, esd4);
      chk(br_tgt_z4 == ebt[0], "R7 branch target z4", br_tgt_z4, ebt);
      chk(br_cnd_z4 == ebc[0], "R7 branch condition z4", br_cnd_z4, ebc);
      chk(pause_if == est, "R5 R6 R7 pause_if", pause_if, est);
      chk(pause_id == est && bubble_ex == est, "R5 pause_id/bubble_ex", {pause_id, bubble_ex}, {est, est});
      if (pause_if) stalls++;
      mc[3] = mc[2]; mra[3] = mra[2]; mrb[3] = mrb[2]; mrc[3] = mrc[2]; mim[3] = mim[2];
      mc[2] = mc[1]; mra[2] = mra[1]; mrb[2] = mrb[1]; mrc[2] = mrc[1]; mim[2] = mim[1];
      if (est) begin
        mc[1] = 0; mra[1] = 0; mrb[1] = 0; mrc[1] = 0; mim[1] = 0;
      end else begin
        mc[1] = c; mra[1] = ra; mrb[1] = rb; mrc[1] = rc; mim[1] = im;
        done = 1'b1;
      end
    end
  endtask

  task automatic drain();
    int s;
    for (int i = 0; i < 3; i++) issue(0, 0, 0, 0, 1'b0, s);
  endtask

  initial begin
    int s;
    for (int k = 1; k <= 3; k++) begin
      mc[k] = 0; mra[k] = 0; mrb[k] = 0; mrc[k] = 0; mim[k] = 0;
    end
    rst = 1'b1;
    d_cls = 3'd0; d_ra = 5'd0; d_rb = 5'd0; d_rc = 5'd0; d_imm = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state with nop in decode
    chk({fwd_x_sel, fwd_y_sel, st_data_sel, st_late_z5, br_tgt_z4, br_cnd_z4,
         pause_if, pause_id, bubble_ex} == '0, "R1 reset outputs",
        {fwd_x_sel, fwd_y_sel, st_data_sel}, 0);
    rst = 1'b0;

    // R6: adjacent ALU dependence needs no stall
    issue(1, 1, 2, 3, 1'b0, s);
    issue(1, 5, 1, 6, 1'b0, s);
    chk(s == 0, "R6 alu-alu stalls", s, 0);
    drain();

    // R6: load then dependent neg
    issue(2, 4, 5, 0, 1'b1, s);
    issue(1, 6, 0, 4, 1'b0, s);
    chk(s == 1, "R6 load-use stalls", s, 1);
    drain();

    // R3: two producers of r2, nearer wins
    issue(1, 2, 3, 4, 1'b0, s);
    issue(1, 2, 5, 6, 1'b0, s);
    issue(1, 7, 2, 2, 1'b0, s);
    issue(0, 0, 0, 0, 1'b0, s);
    issue(1, 8, 9, 7, 1'b0, s);
    drain();

    // R4: immediate form and register zero
    issue(1, 7, 1, 2, 1'b0, s);
    issue(1, 9, 0, 7, 1'b1, s);
    issue(1, 0, 1, 1, 1'b0, s);
    issue(1, 3, 0, 0, 1'b0, s);
    drain();
    issue(2, 12, 1, 0, 1'b1, s);
    issue(1, 3, 0, 12, 1'b1, s);
    chk(s == 0, "R4 immediate no stall", s, 0);
    drain();

    // R7: branch after ALU producer, after load
    issue(1, 8, 1, 2, 1'b0, s);
    issue(5, 0, 8, 3, 1'b0, s);
    chk(s == 1, "R7 branch after alu stalls", s, 1);
    drain();
    issue(2, 9, 1, 0, 1'b1, s);
    issue(6, 1, 9, 0, 1'b0, s);
    chk(s == 2, "R7 branch after load stalls", s, 2);
    drain();
    issue(3, 10, 1, 0, 1'b1, s);
    issue(0, 0, 0, 0, 1'b0, s);
    issue(5, 0, 4, 10, 1'b0, s);
    chk(s == 0, "R7 condition from z4 stalls", s, 0);
    drain();

    // R8: store data never stalls; address modifier after load does
    issue(2, 10, 1, 0, 1'b1, s);
    issue(4, 10, 0, 0, 1'b1, s);
    chk(s == 0, "R8 load-store data stalls", s, 0);
    issue(0, 0, 0, 0, 1'b0, s);
    issue(1, 11, 1, 2, 1'b0, s);
    issue(4, 11, 0, 0, 1'b1, s);
    drain();
    issue(2, 13, 1, 0, 1'b1, s);
    issue(4, 2, 13, 0, 1'b1, s);
    chk(s == 1, "R6 store address after load stalls", s, 1);
    drain();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule